// File: doc/BRIEF.md
# Threshold Pixel Replacement Filter

This block sits in a streaming image path carrying 10-bit samples of a Bayer mosaic. Each sample arrives with a frame-valid, a line-valid and a pixel-valid flag. Two programmable limits mark the healthy range of values. A valid pixel that lies strictly above the upper limit, or strictly below the lower limit, is treated as a defect. Its value is replaced by a value taken from its same-colour neighbours, which sit two samples before and two samples after it on the same line.

A two-bit mode input selects where the replacement comes from:

- the truncated mean of both neighbours,
- the earlier neighbour only,
- the later neighbour only.

At the ends of a line, the one neighbour that exists is used. A bypass input disables all replacement. Every sample and every flag leaves the block exactly four clock cycles after it entered, whatever the mode or bypass setting, so downstream timing never changes.

Top module: `thr_pix_fix`

## Requirements
- R1: A sample that is not replaced leaves on `pix_out` exactly 4 clock cycles after it was presented on `pix_in`, unchanged. This covers samples with `lval_in` or `pval_in` low and valid samples with `thr_lo <= value <= thr_hi`.
- R2: `fval_out`, `lval_out` and `pval_out` equal `fval_in`, `lval_in` and `pval_in` as they were 4 cycles earlier.
- R3: A valid sample whose value is greater than `thr_hi` is replaced. A value equal to `thr_hi` is not replaced.
- R4: A valid sample whose value is less than `thr_lo` is replaced. A value equal to `thr_lo` is not replaced.
- R5: With `mode` = 0 and both neighbours available, the replacement is (earlier + later) >> 1, computed with one extra bit and then truncated.
- R6: With `mode` = 1 and both neighbours available, the replacement is the earlier neighbour, which is the sample presented 2 cycles before the defect.
- R7: With `mode` = 2 and both neighbours available, the replacement is the later neighbour, which is the sample presented 2 cycles after the defect.
- R8: `mode` = 3 gives the same result as `mode` = 0.
- R9: A neighbour counts as available only under three conditions:
  - it has both `lval_in` and `pval_in` high;
  - `lval_in` stays high on every cycle between it and the defect;
  - it lies exactly 2 cycles away from the defect.

  When only one neighbour is available, that neighbour is the replacement in every mode. When neither is available, the sample passes unchanged.
- R10: While `bypass` is high, `pix_out` equals `pix_in` from 4 cycles earlier, for every sample.
- R11: During reset, all outputs are held at 0.
- R12: `thr_hi`, `thr_lo`, `mode` and `bypass` act on the sample that leaves on the clock edge at which they are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| thr_hi | input | 10 | Upper limit; values above it are defects |
| thr_lo | input | 10 | Lower limit; values below it are defects |
| mode | input | 2 | Replacement source: 0 mean, 1 earlier, 2 later, 3 mean |
| bypass | input | 1 | High disables replacement |
| fval_in | input | 1 | Frame valid in |
| lval_in | input | 1 | Line valid in |
| pval_in | input | 1 | Pixel valid in |
| pix_in | input | 10 | Sample in |
| fval_out | output | 1 | Frame valid, delayed 4 cycles |
| lval_out | output | 1 | Line valid, delayed 4 cycles |
| pval_out | output | 1 | Pixel valid, delayed 4 cycles |
| pix_out | output | 10 | Filtered sample, delayed 4 cycles |

## Verification
The bench aims at three groups of corner cases:

- **Limits.** Samples are placed exactly on each limit and one step beyond it. A design using the wrong comparison would replace healthy pixels on the limit, or let a one-step defect through.
- **Short and gapped lines.** Lines of one, two and three pixels are driven, as are lines with a pixel-valid gap. A design that reached across a line boundary or a gap would fetch a neighbour from the wrong line or a stale value, instead of falling back to the single available neighbour or passing the sample through.
- **Mode and bypass.** Every mode and the bypass setting are swept while defects are dense. A design that mixed up the earlier and later taps, rounded the mean instead of truncating it, or let bypass shift the latency would show up as a mismatch against the per-cycle model.

// File: rtl/thr_pix_fix.sv
module thr_pix_fix #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] thr_hi,
  input  logic [DW-1:0] thr_lo,
  input  logic [1:0]    mode,
  input  logic          bypass,
  input  logic          fval_in,
  input  logic          lval_in,
  input  logic          pval_in,
  input  logic [DW-1:0] pix_in,
  output logic          fval_out,
  output logic          lval_out,
  output logic          pval_out,
  output logic [DW-1:0] pix_out
);
  localparam int NB    = 2;
  localparam int DEPTH = 2 * NB + 1;
  localparam int LAST  = DEPTH - 1;

  logic [DEPTH-1:0]         f_q, l_q, p_q;
  logic [DEPTH-1:0][DW-1:0] d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q <= '0;
      l_q <= '0;
      p_q <= '0;
      d_q <= '0;
    end else begin
      f_q <= {f_q[DEPTH-2:0], fval_in};
      l_q <= {l_q[DEPTH-2:0], lval_in};
      p_q <= {p_q[DEPTH-2:0], pval_in};
      d_q <= {d_q[DEPTH-2:0], pix_in};
    end
  end

  wire [DW-1:0] cen   = d_q[NB];
  wire [DW-1:0] lead  = d_q[0];
  wire [DW-1:0] trail = d_q[LAST];

  wire cen_ok   = l_q[NB] & p_q[NB];
  wire lead_ok  = p_q[0] & (&l_q[NB:0]);
  wire trail_ok = p_q[LAST] & (&l_q[LAST:NB]);
  wire bad      = cen_ok & ~bypass & ((cen > thr_hi) | (cen < thr_lo));

  wire [DW:0]   sum = {1'b0, lead} + {1'b0, trail};
  wire [DW-1:0] avg = sum[DW:1];

  logic [DW-1:0] fix;
  always_comb begin
    if (lead_ok && trail_ok) begin
      case (mode)
        2'd1:    fix = trail;
        2'd2:    fix = lead;
        default: fix = avg;
      endcase
    end else if (lead_ok) begin
      fix = lead;
    end else if (trail_ok) begin
      fix = trail;
    end else begin
      fix = cen;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fval_out <= 1'b0;
      lval_out <= 1'b0;
      pval_out <= 1'b0;
      pix_out  <= '0;
    end else begin
      fval_out <= f_q[NB];
      lval_out <= l_q[NB];
      pval_out <= p_q[NB];
      pix_out  <= bad ? fix : cen;
    end
  end

  logic [2:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end
  wire settled = (warm == 3'd4);

  AST_SYNC_FRAME: assert property (@(posedge clk) disable iff (rst)
    settled |-> fval_out == $past(fval_in, 4)); // R2
  AST_SYNC_LINE: assert property (@(posedge clk) disable iff (rst)
    settled |-> (lval_out == $past(lval_in, 4) && pval_out == $past(pval_in, 4))); // R2
  AST_BYPASS_TRANSPARENT: assert property (@(posedge clk) disable iff (rst)
    (settled && $past(bypass)) |-> pix_out == $past(pix_in, 4)); // R10
  AST_INVALID_PASS: assert property (@(posedge clk) disable iff (rst)
    (settled && !(lval_out && pval_out)) |-> pix_out == $past(pix_in, 4)); // R1
  AST_INRANGE_PASS: assert property (@(posedge clk) disable iff (rst)
    (settled && $past(pix_in, 4) <= $past(thr_hi) && $past(pix_in, 4) >= $past(thr_lo))
      |-> pix_out == $past(pix_in, 4)); // R1
endmodule

// File: tb/sim_thr_pix_fix.sv
module sim_thr_pix_fix;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [9:0] thr_hi = 10'd900, thr_lo = 10'd100;
  logic [1:0] mode = 2'd0;
  logic bypass = 1'b0;
  logic fval_in = 1'b0, lval_in = 1'b0, pval_in = 1'b0;
  logic [9:0] pix_in = '0;
  logic fval_out, lval_out, pval_out;
  logic [9:0] pix_out;

  always #10 clk = ~clk;

  thr_pix_fix u0 (
    .clk(clk), .rst(rst), .thr_hi(thr_hi), .thr_lo(thr_lo), .mode(mode),
    .bypass(bypass), .fval_in(fval_in), .lval_in(lval_in), .pval_in(pval_in),
    .pix_in(pix_in), .fval_out(fval_out), .lval_out(lval_out),
    .pval_out(pval_out), .pix_out(pix_out));

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  int hd[6], hf[6], hl[6], hp[6];
  int ed, ef, el, ep;
  string etag = "R11";

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int k = 0; k < 6; k++) begin hd[k] = 0; hf[k] = 0; hl[k] = 0; hp[k] = 0; end
      ed = 0; ef = 0; el = 0; ep = 0; etag = "R11";
    end else begin
      int c;
      bit lok, tok, isbad;
      c  = hd[3];
      ef = hf[3]; el = hl[3]; ep = hp[3];
      lok = hl[1] && hp[1] && hl[2] && hl[3];
      tok = hl[5] && hp[5] && hl[4] && hl[3];
      isbad = hl[3] && hp[3] && (c > int'(thr_hi) || c < int'(thr_lo)) && !bypass;
      if (bypass) begin
        ed = c; etag = "R10";
      end else if (!isbad) begin
        ed = c; etag = "R1 R12";
      end else if (lok && tok) begin
        case (mode)
          2'd1: begin ed = hd[5]; etag = "R6"; end
          2'd2: begin ed = hd[1]; etag = "R7"; end
          2'd3: begin ed = (hd[1] + hd[5]) / 2; etag = "R8"; end
          default: begin ed = (hd[1] + hd[5]) / 2; etag = "R5"; end
        endcase
        etag = {etag, (c > int'(thr_hi)) ? " R3" : " R4"};
      end else if (lok) begin
        ed = hd[1]; etag = "R9";
      end else if (tok) begin
        ed = hd[5]; etag = "R9";
      end else begin
        ed = c; etag = "R9";
      end
      for (int k = 5; k > 1; k--) begin
        hd[k] = hd[k-1]; hf[k] = hf[k-1]; hl[k] = hl[k-1]; hp[k] = hp[k-1];
      end
      hd[1] = int'(pix_in); hf[1] = int'(fval_in); hl[1] = int'(lval_in); hp[1] = int'(pval_in);
    end
  end

  always @(negedge clk) begin
    if (!done && cycles > 0) begin
      checks++;
      if (int'(pix_out) != ed) begin
        fails++;
        $display("FAIL %s pix_out=%0d expected=%0d at cycle %0d", etag, pix_out, ed, cycles);
      end
      checks++;
      if (int'(fval_out) != ef || int'(lval_out) != el || int'(pval_out) != ep) begin
        fails++;
        $display("FAIL R2 sync=%0d%0d%0d expected=%0d%0d%0d at cycle %0d",
                 fval_out, lval_out, pval_out, ef, el, ep, cycles);
      end
    end
  end

  function automatic logic [9:0] pick();
    int r;
    r = int'($urandom % 10);
    case (r)
      0: return 10'd1023;
      1: return 10'd0;
      2: return thr_hi;
      3: return thr_lo;
      4: return thr_hi + 10'd1;
      5: return thr_lo - 10'd1;
      default: return 10'(int'(thr_lo) + int'($urandom % (int'(thr_hi) - int'(thr_lo) + 1)));
    endcase
  endfunction

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lval_in = 1'b0; pval_in = 1'b0; pix_in = 10'($urandom % 1024);
    end
  endtask

  task automatic line(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lval_in = 1'b1; pval_in = (i != gap); pix_in = pick();
    end
    idle(3);
  endtask

  task automatic frame(input int lines);
    @(negedge clk); fval_in = 1'b1;
    for (int j = 0; j < lines; j++) line(6 + j % 9, (j % 4 == 1) ? 3 : -1);
    line(1, -1); line(2, -1); line(3, -1);
    @(negedge clk); fval_in = 1'b0;
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pix_out !== 10'd0 || fval_out !== 1'b0 || lval_out !== 1'b0 || pval_out !== 1'b0) begin
      fails++;
      $display("FAIL R11 outputs=%0d/%b%b%b expected=0/000", pix_out, fval_out, lval_out, pval_out);
    end
    @(negedge clk); rst = 1'b0;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); mode = 2'(m);
      frame(12);
    end
    @(negedge clk); bypass = 1'b1;
    frame(8);
    @(negedge clk); bypass = 1'b0; thr_hi = 10'd512; thr_lo = 10'd511; mode = 2'd0;
    frame(10);
    @(negedge clk); thr_hi = 10'd1023; thr_lo = 10'd0;
    frame(4);
    @(negedge clk); thr_hi = 10'd700; thr_lo = 10'd300; mode = 2'd2;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk);
      bypass = ($urandom % 3 == 0); mode = 2'($urandom % 4);
      fval_in = 1'b1; lval_in = ($urandom % 8 != 0); pval_in = ($urandom % 5 != 0);
      pix_in = pick();
    end
    idle(8);
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired at cycle %0d expected completion", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule